// File: doc/BRIEF.md
# Counter Compare Output Unit

This block watches a running counter value and compares it against a stored comparison value. It drives one digital output together with an output-status bit, a sticky comparator-status bit and a one-clock interrupt strobe. The counter lives outside the block. The block samples the counter value once per clock, together with the direction in which the counter is moving. A 1 ms tick input times the pulse output.

Four output modes are available. In the off mode the output is a plain software-driven bit. In the two threshold modes the output is on while the count sits at or above, or at or below, the comparison value. In the pulse mode the output is on for a programmed time after the count reaches the comparison value. The pulse mode can be limited to reaches in one counting direction. A running pulse is never restarted or extended. The comparator-status bit stays set until software asks to clear it, and the block honours that request only once the condition behind the flag has gone.

Configuration is written through load strobes: one for the comparison value, one for the pulse length, and one for the mode and direction qualifier. Each loaded value is used from the following clock onward. A mode load cancels any running pulse and clears the output and the status bits for one cycle.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset the output, the output-status bit, the comparator-status bit and the interrupt strobe are all 0, and the mode is off.
- R2: In off mode (mode code 0), `dout` follows `sw_out` with one clock of latency. `out_en` has no effect, and `cmp_sts`, `dout_sts` and `irq` all stay 0.
- R3: In at-or-above mode (mode code 1), `dout` in the cycle after a sample equals `out_en AND (cnt_val >= comparison value)`.
- R4: In at-or-below mode (mode code 2), `dout` in the cycle after a sample equals `out_en AND (cnt_val <= comparison value)`.
- R5: In modes 1 and 2, `cmp_sts` is set whenever the condition holds. While it is set, it is cleared only by `sts_clr` in a cycle where the condition is false.
- R6: A reach is a counter sample equal to the comparison value whose preceding sample differed from it. In modes 1 and 2 every reach, and in mode 3 every direction-qualified reach, gives a one-clock `irq` pulse in the following cycle.
- R7: In pulse mode (mode code 3) with a non-zero length N, a qualified reach while `out_en` is 1 and no pulse is running turns `dout` on from the next cycle. `dout` turns off with the 2N-th tick after the start.
- R8: The direction qualifier code 1 accepts only reaches with `cnt_up`=1, code 2 accepts only reaches with `cnt_up`=0, and codes 0 and 3 accept both.
- R9: While a pulse runs, further reaches neither restart nor extend it.
- R10: A pulse length loaded while a pulse runs does not change that pulse; it is used by the next one.
- R11: In pulse mode with length 0 and no pulse running, `dout` follows `out_en AND (cnt_val == comparison value)`, and `cmp_sts` behaves as in R5 with equality as the condition.
- R12: In pulse mode `cmp_sts` is set when a pulse starts, and `sts_clr` is ignored until the pulse has ended.
- R13: In modes 1 to 3, `dout_sts` equals `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | CNT_W | Current counter sample |
| cnt_up | input | 1 | 1 when the counter is counting up |
| ld_cmp | input | 1 | Load strobe for the comparison value |
| cmp_in | input | CNT_W | Comparison value to load |
| ld_len | input | 1 | Load strobe for the pulse length |
| len_in | input | LEN_W | Pulse length in steps of STEP_TICKS ticks |
| cfg_ld | input | 1 | Load strobe for mode and direction qualifier |
| mode_in | input | 2 | Mode code: 0 off, 1 at-or-above, 2 at-or-below, 3 pulse |
| dir_in | input | 2 | Direction qualifier: 0 or 3 any, 1 up, 2 down |
| out_en | input | 1 | Output-enable control bit |
| sw_out | input | 1 | Output value used in off mode |
| sts_clr | input | 1 | Request to clear the comparator-status bit |
| tick_1ms | input | 1 | One-clock time-base tick |
| dout | output | 1 | Digital output |
| dout_sts | output | 1 | Output-status bit |
| cmp_sts | output | 1 | Comparator-status bit |
| irq | output | 1 | Interrupt strobe |

## Verification
The hardest situations to reach are inside a running pulse. These are a second reach of the comparison value, a new length being loaded, and a status-clear request arriving before the final tick. Random stimulus seldom lines these up. Directed phases therefore start a pulse with a slow tick rate and then move the counter off and back onto the value. In the same pulse they load a different length and pulse `sts_clr`. They then let a second pulse run to show the new length. The random phase then walks the counter in small steps around the comparison value, so that reaches in both directions are frequent.

// File: rtl/cmpo_pkg.sv
package cmpo_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_GE    = 2'd1,
    MODE_LE    = 2'd2,
    MODE_PULSE = 2'd3
  } cmpo_mode_e;

  typedef enum logic [1:0] {
    DIR_ANY  = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2,
    DIR_BOTH = 2'd3
  } cmpo_dir_e;
endpackage

// File: rtl/cmpo_cfg.sv
module cmpo_cfg
  import cmpo_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_cmp,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             ld_len,
  input  logic [LEN_W-1:0] len_in,
  input  logic             cfg_ld,
  input  logic [1:0]       mode_in,
  input  logic [1:0]       dir_in,
  output logic [CNT_W-1:0] cmp_q,
  output logic [LEN_W-1:0] len_q,
  output cmpo_mode_e       mode_q,
  output cmpo_dir_e        dir_q
);
  logic [CNT_W-1:0] cmp_n;
  logic [LEN_W-1:0] len_n;
  cmpo_mode_e       mode_n;
  cmpo_dir_e        dir_n;

  always_comb begin
    cmp_n  = cmp_q;
    len_n  = len_q;
    mode_n = mode_q;
    dir_n  = dir_q;
    if (ld_cmp) cmp_n = cmp_in;
    if (ld_len) len_n = len_in;
    if (cfg_ld) begin
      mode_n = cmpo_mode_e'(mode_in);
      dir_n  = cmpo_dir_e'(dir_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      len_q  <= '0;
      mode_q <= MODE_OFF;
      dir_q  <= DIR_ANY;
    end else begin
      cmp_q  <= cmp_n;
      len_q  <= len_n;
      mode_q <= mode_n;
      dir_q  <= dir_n;
    end
  end

  a_r1_loaded_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ld |=> (mode_q == cmpo_mode_e'($past(mode_in))));
endmodule

// File: rtl/cmpo_reach.sv
module cmpo_reach
  import cmpo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_up,
  input  logic [CNT_W-1:0] cmp_q,
  input  cmpo_dir_e        dir_q,
  output logic             eq,
  output logic             ge,
  output logic             le,
  output logic             reach,
  output logic             reach_qual
);
  logic [CNT_W-1:0] prev_q;
  logic             pv_q;
  logic             dir_ok;

  always_comb begin
    eq    = (cnt_val == cmp_q);
    ge    = (cnt_val >= cmp_q);
    le    = (cnt_val <= cmp_q);
    reach = pv_q && eq && (prev_q != cmp_q);
    unique case (dir_q)
      DIR_UP:   dir_ok = cnt_up;
      DIR_DOWN: dir_ok = !cnt_up;
      default:  dir_ok = 1'b1;
    endcase
    reach_qual = reach && dir_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      prev_q <= cnt_val;
      pv_q   <= 1'b1;
    end
  end

  a_r8_qual_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (reach_qual && dir_q == DIR_UP) |-> cnt_up);
  a_r6_reach_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (reach && $stable(cmp_q)) |=> !reach);
endmodule

// File: rtl/cmpo_pulse_timer.sv
module cmpo_pulse_timer #(
  parameter int LEN_W      = 8,
  parameter int STEP_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             active_q,
  output logic             end_now
);
  localparam int MAX_TICKS = ((1 << LEN_W) - 1) * STEP_TICKS;
  localparam int REM_W     = $clog2(MAX_TICKS + 1);

  logic [REM_W-1:0] rem_q, rem_n;
  logic             active_n;
  logic             start_ok;

  always_comb begin
    start_ok = start && !active_q && (len != '0);
    end_now  = active_q && tick && (rem_q == REM_W'(1));
    rem_n    = rem_q;
    active_n = active_q;
    if (abort) begin
      active_n = 1'b0;
      rem_n    = '0;
    end else if (start_ok) begin
      active_n = 1'b1;
      rem_n    = REM_W'(len) * REM_W'(STEP_TICKS);
    end else if (active_q && tick) begin
      rem_n = rem_q - REM_W'(1);
      if (end_now) active_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      active_q <= 1'b0;
    end else begin
      rem_q    <= rem_n;
      active_q <= active_n;
    end
  end

  a_r9_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !tick && !abort) |=> $stable(rem_q));
  a_r7_load_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> (rem_q == REM_W'($past(len)) * REM_W'(STEP_TICKS)));
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
  import cmpo_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int LEN_W      = 8,
  parameter int STEP_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_up,
  input  logic             ld_cmp,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             ld_len,
  input  logic [LEN_W-1:0] len_in,
  input  logic             cfg_ld,
  input  logic [1:0]       mode_in,
  input  logic [1:0]       dir_in,
  input  logic             out_en,
  input  logic             sw_out,
  input  logic             sts_clr,
  input  logic             tick_1ms,
  output logic             dout,
  output logic             dout_sts,
  output logic             cmp_sts,
  output logic             irq
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [CNT_W-1:0] cmp_q;
  logic [LEN_W-1:0] len_q;
  cmpo_mode_e       mode_q;
  cmpo_dir_e        dir_q;
  logic             eq, ge, le, reach, reach_qual;
  logic             tmr_active, tmr_end, start_now;
  logic             dout_q, dout_n, sts_q, sts_n, irq_q, irq_n;
  logic             direct;

  cmpo_cfg #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n_i), .ld_cmp(ld_cmp), .cmp_in(cmp_in),
    .ld_len(ld_len), .len_in(len_in), .cfg_ld(cfg_ld), .mode_in(mode_in),
    .dir_in(dir_in), .cmp_q(cmp_q), .len_q(len_q), .mode_q(mode_q),
    .dir_q(dir_q)
  );

  cmpo_reach #(.CNT_W(CNT_W)) u_reach (
    .clk(clk), .rst_n(rst_n_i), .cnt_val(cnt_val), .cnt_up(cnt_up),
    .cmp_q(cmp_q), .dir_q(dir_q), .eq(eq), .ge(ge), .le(le),
    .reach(reach), .reach_qual(reach_qual)
  );

  cmpo_pulse_timer #(.LEN_W(LEN_W), .STEP_TICKS(STEP_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .start(start_now), .abort(cfg_ld),
    .tick(tick_1ms), .len(len_q), .active_q(tmr_active), .end_now(tmr_end)
  );

  always_comb begin
    direct    = (len_q == '0) && !tmr_active;
    start_now = 1'b0;
    dout_n    = 1'b0;
    sts_n     = 1'b0;
    irq_n     = 1'b0;
    unique case (mode_q)
      MODE_OFF: begin
        dout_n = sw_out;
      end
      MODE_GE: begin
        dout_n = out_en && ge;
        sts_n  = ge || (sts_q && !sts_clr);
        irq_n  = reach;
      end
      MODE_LE: begin
        dout_n = out_en && le;
        sts_n  = le || (sts_q && !sts_clr);
        irq_n  = reach;
      end
      MODE_PULSE: begin
        irq_n = reach_qual;
        if (direct) begin
          dout_n = out_en && eq;
          sts_n  = eq || (sts_q && !sts_clr);
        end else begin
          start_now = reach_qual && out_en && !tmr_active;
          dout_n    = start_now || (tmr_active && !tmr_end);
          sts_n     = start_now || (sts_q && !(sts_clr && !tmr_active));
        end
      end
      default: dout_n = 1'b0;
    endcase
    if (cfg_ld) begin
      start_now = 1'b0;
      dout_n    = 1'b0;
      sts_n     = 1'b0;
      irq_n     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dout_q <= 1'b0;
      sts_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      dout_q <= dout_n;
      sts_q  <= sts_n;
      irq_q  <= irq_n;
    end
  end

  assign dout     = dout_q;
  assign dout_sts = dout_q && (mode_q != MODE_OFF);
  assign cmp_sts  = sts_q;
  assign irq      = irq_q;

  a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode_q == MODE_OFF) |-> (!cmp_sts && !irq));
  a_r3_ge_follow: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode_q == MODE_GE && !cfg_ld) |=> (dout == $past(out_en && ge)));
  a_r5_sts_sticky: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((mode_q == MODE_LE) && cmp_sts && le && !cfg_ld) |=> cmp_sts);
  a_r12_pulse_sts: assert property (@(posedge clk) disable iff (!rst_n_i)
    ((mode_q == MODE_PULSE) && cmp_sts && tmr_active && !cfg_ld) |=> cmp_sts);
  a_r13_sts_mirror: assert property (@(posedge clk) disable iff (!rst_n_i)
    (mode_q != MODE_OFF) |-> (dout_sts == dout));
endmodule

// File: tb/cmp_out_unit_tb.sv
module cmp_out_unit_tb;
  localparam int CNT_W = 16;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_up, ld_cmp, ld_len, cfg_ld, out_en, sw_out, sts_clr, tick_1ms;
  logic [CNT_W-1:0] cmp_in;
  logic [LEN_W-1:0] len_in;
  logic [1:0]       mode_in, dir_in;
  logic             dout, dout_sts, cmp_sts, irq;

  int n_chk = 0;
  int n_bad = 0;
  string focus = "";

  always #2 clk = ~clk;

  cmp_out_unit #(.CNT_W(CNT_W), .LEN_W(LEN_W), .STEP_TICKS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_up(cnt_up),
    .ld_cmp(ld_cmp), .cmp_in(cmp_in), .ld_len(ld_len), .len_in(len_in),
    .cfg_ld(cfg_ld), .mode_in(mode_in), .dir_in(dir_in), .out_en(out_en),
    .sw_out(sw_out), .sts_clr(sts_clr), .tick_1ms(tick_1ms), .dout(dout),
    .dout_sts(dout_sts), .cmp_sts(cmp_sts), .irq(irq)
  );

  // reference state, built from the requirements
  logic [CNT_W-1:0] m_prev, m_cmp;
  logic [LEN_W-1:0] m_len;
  logic [1:0]       m_mode, m_dir;
  logic             m_act, m_dout, m_sts, m_irq;
  int               m_rem;

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic eq, ge, le, reach, qual, dir_ok, direct, start, fin;
    logic nd, ns, ni;
    eq = (cnt_val == m_cmp); ge = (cnt_val >= m_cmp); le = (cnt_val <= m_cmp);
    reach = eq && (m_prev != m_cmp);
    dir_ok = (m_dir == 2'd1) ? cnt_up : (m_dir == 2'd2) ? !cnt_up : 1'b1;
    qual = reach && dir_ok;
    direct = (m_len == 0) && !m_act;
    fin = m_act && tick_1ms && (m_rem == 1);
    start = 1'b0; nd = 1'b0; ns = 1'b0; ni = 1'b0;
    case (m_mode)
      2'd0: nd = sw_out;
      2'd1: begin nd = out_en && ge; ns = ge || (m_sts && !sts_clr); ni = reach; end
      2'd2: begin nd = out_en && le; ns = le || (m_sts && !sts_clr); ni = reach; end
      default: begin
        ni = qual;
        if (direct) begin
          nd = out_en && eq; ns = eq || (m_sts && !sts_clr);
        end else begin
          start = qual && out_en && !m_act;
          nd = start || (m_act && !fin);
          ns = start || (m_sts && !(sts_clr && !m_act));
        end
      end
    endcase
    if (cfg_ld) begin
      start = 1'b0; nd = 1'b0; ns = 1'b0; ni = 1'b0;
      m_act = 1'b0; m_rem = 0;
    end else if (start && m_len != 0) begin
      m_act = 1'b1; m_rem = 2 * int'(m_len);
    end else if (m_act && tick_1ms) begin
      m_rem--;
      if (m_rem == 0) m_act = 1'b0;
    end
    m_dout = nd; m_sts = ns; m_irq = ni;
    if (ld_cmp) m_cmp = cmp_in;
    if (ld_len) m_len = len_in;
    if (cfg_ld) begin m_mode = mode_in; m_dir = dir_in; end
    m_prev = cnt_val;
  endtask

  task automatic cyc();
    string td, ts;
    model_step();
    @(posedge clk); #1;
    case (m_mode)
      2'd0: begin td = "R2"; ts = "R2"; end
      2'd1: begin td = "R3"; ts = "R5"; end
      2'd2: begin td = "R4"; ts = "R5"; end
      default: begin td = (m_len == 0 && !m_act) ? "R11" : "R7"; ts = "R12"; end
    endcase
    if (focus != "") begin td = focus; ts = focus; end
    check({td, " dout"}, dout, m_dout);
    check({ts, " cmp_sts"}, cmp_sts, m_sts);
    check((focus != "") ? {focus, " irq"} : "R6 irq", irq, m_irq);
    check((focus != "") ? {focus, " dout_sts"} : "R13 dout_sts", dout_sts,
          m_dout && (m_mode != 2'd0));
    ld_cmp = 0; ld_len = 0; cfg_ld = 0; sts_clr = 0; tick_1ms = 0;
  endtask

  task automatic set_mode(input logic [1:0] m, input logic [1:0] d);
    cfg_ld = 1; mode_in = m; dir_in = d; cyc();
  endtask

  task automatic go(input int v, input logic up);
    cnt_val = CNT_W'(v); cnt_up = up; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; cnt_val = 0; cnt_up = 1; ld_cmp = 0; cmp_in = 0; ld_len = 0;
    len_in = 0; cfg_ld = 0; mode_in = 0; dir_in = 0; out_en = 0; sw_out = 0;
    sts_clr = 0; tick_1ms = 0;
    m_prev = 0; m_cmp = 0; m_len = 0; m_mode = 0; m_dir = 0;
    m_act = 0; m_rem = 0; m_dout = 0; m_sts = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 dout", dout, 1'b0);
    check("R1 dout_sts", dout_sts, 1'b0);
    check("R1 cmp_sts", cmp_sts, 1'b0);
    check("R1 irq", irq, 1'b0);

    // R2: off mode, out_en irrelevant
    focus = "R2";
    sw_out = 1; out_en = 0; cyc();
    out_en = 1; sw_out = 0; cyc();
    sw_out = 1; cyc();
    focus = "";

    // R3/R5: at-or-above
    ld_cmp = 1; cmp_in = 10; cyc();
    set_mode(2'd1, 2'd0);
    for (int i = 7; i <= 12; i++) go(i, 1);
    sts_clr = 1; go(11, 0);
    for (int i = 10; i >= 7; i--) go(i, 0);
    sts_clr = 1; go(7, 0);
    // R4: at-or-below
    set_mode(2'd2, 2'd0);
    for (int i = 8; i <= 12; i++) go(i, 1);

    // R8: up-only pulse ignores downward reach
    ld_len = 1; len_in = 2; cyc();
    set_mode(2'd3, 2'd1);
    focus = "R8";
    go(12, 0); go(11, 0); go(10, 0); go(9, 0);
    go(10, 1);
    for (int i = 0; i < 8; i++) begin tick_1ms = (i % 2 == 0); go(10, 1); end
    focus = "";

    // R9/R10/R12: reach again, new length and clear during a pulse
    set_mode(2'd3, 2'd0);
    go(9, 1); go(10, 1);
    focus = "R9";
    go(11, 1); go(10, 0); tick_1ms = 1; go(11, 1); go(10, 0);
    focus = "R12";
    sts_clr = 1; go(10, 0);
    focus = "R10";
    ld_len = 1; len_in = 1; go(11, 1);
    for (int i = 0; i < 6; i++) begin tick_1ms = 1; go(11, 1); end
    sts_clr = 1; go(11, 1);
    go(10, 0);
    for (int i = 0; i < 4; i++) begin tick_1ms = 1; go(10, 0); end
    focus = "";

    // R11: zero length follows equality
    ld_len = 1; len_in = 0; go(10, 0);
    go(11, 1); go(10, 0); go(9, 0); sts_clr = 1; go(9, 0);

    // random phase
    for (int r = 0; r < 4000; r++) begin
      int v;
      if (($urandom % 250) == 0) begin
        cfg_ld = 1; mode_in = 2'($urandom); dir_in = 2'($urandom);
      end
      if (($urandom % 150) == 0) begin ld_len = 1; len_in = LEN_W'($urandom % 5); end
      if (($urandom % 400) == 0) begin ld_cmp = 1; cmp_in = CNT_W'(8 + $urandom % 5); end
      out_en = ($urandom % 10) != 0;
      sw_out = 1'($urandom);
      sts_clr = ($urandom % 8) == 0;
      tick_1ms = ($urandom % 4) == 0;
      v = int'(cnt_val) + int'($urandom % 3) - 1;
      if (v < 4) v = 4;
      if (v > 16) v = 16;
      cnt_up = (v > int'(cnt_val)) ? 1'b1 : (v < int'(cnt_val)) ? 1'b0 : cnt_up;
      cnt_val = CNT_W'(v);
      cyc();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule